// File: doc/BRIEF.md
# Shared Receive Packet Queue with Overflow Rewind

This block is the receive store of a USB device. Bytes for every OUT endpoint land in one circular buffer, one packet at a time. A packet stays invisible to the consumer until the link layer strobes its end and reports it good. On that strobe the block appends one status word after the packet's bytes. The status word carries the endpoint number, the byte count, a 2-bit data PID code and a valid flag. A DMA-style consumer drains data words and status words in arrival order through a valid/ready stream, and it may do so while later packets are still arriving.

Each packet is written speculatively. If the buffer runs out of room before the packet and its status word are both stored, the block pulses `nak_pulse` so that the link layer answers the OUT token with NAK. It then moves its write pointer back to the packet's first entry, so no trace of the packet remains. A packet the link layer marks bad, for example after a CRC failure, is dropped the same way without a NAK. The write side has no ready signal, because a link layer mid-packet cannot be stalled. Bytes that do not fit are absorbed and dropped, and `nak_pulse` reports the loss. On the read side, `out_word` and `out_is_stat` hold steady while `out_valid` is high and `out_ready` is low, and a word is consumed on every cycle where both are high.

Top module: `rx_pkt_fifo`

## Requirements
- R1: All endpoints share one buffer. A data word has `out_is_stat`=0 and the byte in `out_word[7:0]`. A status word has `out_is_stat`=1 with endpoint in bits 17:14, byte count in bits 13:3, PID code in bits 2:1 and the valid flag (always 1 for a stored packet) in bit 0.
- R2: Words leave in write order: a packet's bytes in arrival order, then its status word, with packets in commit order.
- R3: Bytes of an unfinished packet are not readable and are not counted in `level`. A good end strobe raises `level` by the packet's byte count plus one in the next cycle.
- R4: A packet is accepted exactly when its bytes plus one status entry fit in the free entries (depth minus speculative occupancy). An exact fit is accepted.
- R5: If a byte, or the good end strobe's status word, finds no free entry, `nak_pulse` is high for one cycle after that edge. The partial packet is rewound, and committed data and `level` are unchanged.
- R6: After an overflow, further bytes of that packet are ignored. Its end strobe writes no status and raises no second NAK, and the next packet is stored normally.
- R7: A packet ended with `end_good`=0 is discarded with no status word and no NAK.
- R8: The consumer may drain committed words in the same cycles in which new bytes are written.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_word` and `out_is_stat` stay unchanged. A word is popped on a cycle with both high.
- R10: `full` is high when the speculative occupancy equals the depth. `empty` is high when no committed word is readable.
- R11: After reset, `empty`=1, `full`=0, `level`=0, `out_valid`=0 and `nak_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet byte is present this cycle (never together with end_valid) |
| in_byte | input | 8 | Packet byte |
| end_valid | input | 1 | End-of-packet strobe |
| end_good | input | 1 | Packet passed link checks |
| end_pid | input | 2 | Data PID code for the status word |
| end_ep | input | 4 | OUT endpoint number |
| nak_pulse | output | 1 | One-cycle request to answer the packet with NAK |
| out_valid | output | 1 | A committed word is available |
| out_ready | input | 1 | Consumer takes the word |
| out_is_stat | output | 1 | Current word is a status word |
| out_word | output | 18 | Data byte (zero-extended) or status word |
| full | output | 1 | Speculative occupancy equals depth |
| empty | output | 1 | No committed word to read |
| level | output | AW+1 | Committed words waiting to be read |

## Verification
The bench aims at the boundary of space. A packet that exactly fills the buffer must commit and raise `full`. A packet one byte longer must NAK on the status word. One two bytes longer must NAK on a data byte and ignore the rest. A design that counted the status entry wrongly would either NAK the exact fit or overwrite unread data. A design that rewound to the wrong place would leave stray bytes, and the following packet's contents would then be misread. The bench also pops words while a new packet is being written and checks that the speculative bytes stay hidden and out of `level`. A design that exposed the speculative pointer to the reader would show uncommitted or later-discarded bytes. Bad packets must vanish without a NAK, and held output words must not change under back-pressure.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int BYTE_W = 8;
  localparam int EP_W   = 4;
  localparam int CNT_W  = 11;
  localparam int PID_W  = 2;
  localparam int STAT_W = EP_W + CNT_W + PID_W + 1;

  typedef struct packed {
    logic              is_stat;
    logic [STAT_W-1:0] body;
  } rxq_entry_t;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic [EP_W-1:0]  ep,
    input logic [CNT_W-1:0] cnt,
    input logic [PID_W-1:0] pid
  );
    return {ep, cnt, pid, 1'b1};
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rxq_entry_t    wentry,
  input  logic [AW-1:0] raddr,
  output rxq_entry_t    rentry
);
  localparam int DEPTH = 1 << AW;

  rxq_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign rentry = mem[raddr];
endmodule

// File: rtl/rxq_wr_ctl.sv
module rxq_wr_ctl
  import rxq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              end_valid,
  input  logic              end_good,
  input  logic [PID_W-1:0]  end_pid,
  input  logic [EP_W-1:0]   end_ep,
  input  logic [AW:0]       rd_ptr,
  output logic [AW:0]       wr_com,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output rxq_entry_t        wentry,
  output logic              full,
  output logic              nak_pulse
);
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [AW:0]      wr_spec;
  logic [CNT_W-1:0] byte_cnt;
  logic             dropping;
  logic [AW:0]      spec_cnt;
  logic             room, live, byte_wr, byte_ovf, stat_wr, end_ovf;

  always_comb begin
    spec_cnt = wr_spec - rd_ptr;
    room     = (spec_cnt != FULL_CNT);
    live     = !dropping;
    byte_wr  = in_valid && live && room;
    byte_ovf = in_valid && live && !room;
    stat_wr  = end_valid && live && end_good && room;
    end_ovf  = end_valid && live && end_good && !room;
    we       = byte_wr || stat_wr;
    waddr    = wr_spec[AW-1:0];
    wentry.is_stat = stat_wr;
    wentry.body    = stat_wr ? pack_status(end_ep, byte_cnt, end_pid)
                             : STAT_W'(in_byte);
    full     = !room;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_spec   <= '0;
      wr_com    <= '0;
      byte_cnt  <= '0;
      dropping  <= 1'b0;
      nak_pulse <= 1'b0;
    end else begin
      nak_pulse <= byte_ovf || end_ovf;
      if (byte_wr) begin
        wr_spec  <= wr_spec + 1'b1;
        byte_cnt <= byte_cnt + 1'b1;
      end
      if (byte_ovf) begin
        wr_spec  <= wr_com;
        byte_cnt <= '0;
        dropping <= 1'b1;
      end
      if (end_valid) begin
        byte_cnt <= '0;
        dropping <= 1'b0;
        if (stat_wr) begin
          wr_spec <= wr_spec + 1'b1;
          wr_com  <= wr_spec + 1'b1;
        end else begin
          wr_spec <= wr_com;
        end
      end
    end
  end
endmodule

// File: rtl/rxq_rd_ctl.sv
module rxq_rd_ctl #(
  parameter int AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [AW:0] wr_com,
  input  logic        out_ready,
  output logic [AW:0] rd_ptr,
  output logic        out_valid,
  output logic        empty,
  output logic [AW:0] level
);
  always_comb begin
    level     = wr_com - rd_ptr;
    out_valid = (level != '0);
    empty     = !out_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      rd_ptr <= '0;
    else if (out_valid && out_ready) rd_ptr <= rd_ptr + 1'b1;
  end
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              end_valid,
  input  logic              end_good,
  input  logic [PID_W-1:0]  end_pid,
  input  logic [EP_W-1:0]   end_ep,
  output logic              nak_pulse,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_stat,
  output logic [STAT_W-1:0] out_word,
  output logic              full,
  output logic              empty,
  output logic [AW:0]       level
);
  logic [AW:0]   rd_ptr, wr_com;
  logic          we;
  logic [AW-1:0] waddr;
  rxq_entry_t    wentry, rentry;

  rxq_wr_ctl #(.AW(AW)) wr_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .end_valid(end_valid), .end_good(end_good), .end_pid(end_pid),
    .end_ep(end_ep), .rd_ptr(rd_ptr), .wr_com(wr_com), .we(we),
    .waddr(waddr), .wentry(wentry), .full(full), .nak_pulse(nak_pulse)
  );

  rxq_rd_ctl #(.AW(AW)) rd_i (
    .clk(clk), .rst_n(rst_n), .wr_com(wr_com), .out_ready(out_ready),
    .rd_ptr(rd_ptr), .out_valid(out_valid), .empty(empty), .level(level)
  );

  rxq_store #(.AW(AW)) mem_i (
    .clk(clk), .we(we), .waddr(waddr), .wentry(wentry),
    .raddr(rd_ptr[AW-1:0]), .rentry(rentry)
  );

  assign out_is_stat = rentry.is_stat;
  assign out_word    = rentry.body;
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int AW = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        end_valid,
  input logic        nak_pulse,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_is_stat,
  input logic [17:0] out_word,
  input logic        full,
  input logic [AW:0] level
);
  localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  // R5
  nak_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak_pulse |-> $past(in_valid || end_valid));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_is_stat)));

  // R3
  commit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level > $past(level)) |-> $past(end_valid));

  // R10
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == FULL_CNT) |-> full);

  // R1
  stat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_stat) |-> out_word[0]);
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .end_valid(end_valid),
  .nak_pulse(nak_pulse), .out_valid(out_valid), .out_ready(out_ready),
  .out_is_stat(out_is_stat), .out_word(out_word), .full(full), .level(level)
);

// File: tb/rx_pkt_fifo_tb_top.sv
module rx_pkt_fifo_tb_top;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [7:0] nb;
    logic [7:0] first;
    logic [1:0] pid;
    logic [3:0] ep;
    logic       good;
    logic       exp_nak;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'd3,  8'h10, 2'd0, 4'd1,  1'b1, 1'b0},
    '{8'd0,  8'h00, 2'd1, 4'd2,  1'b1, 1'b0},
    '{8'd15, 8'h40, 2'd2, 4'd15, 1'b1, 1'b0},
    '{8'd16, 8'h60, 2'd3, 4'd3,  1'b1, 1'b1},
    '{8'd17, 8'h80, 2'd0, 4'd4,  1'b1, 1'b1},
    '{8'd5,  8'hA0, 2'd1, 4'd5,  1'b0, 1'b0},
    '{8'd8,  8'hC0, 2'd3, 4'd7,  1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, end_valid = 1'b0, end_good = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [1:0]  end_pid = '0;
  logic [3:0]  end_ep = '0;
  logic        nak_pulse, out_valid, out_is_stat, full, empty;
  logic [17:0] out_word;
  logic [AW:0] level;

  int checks = 0, fails = 0, nak_cnt = 0;

  always #5 clk = ~clk;

  rx_pkt_fifo #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .end_valid(end_valid), .end_good(end_good), .end_pid(end_pid), .end_ep(end_ep),
    .nak_pulse(nak_pulse), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_stat(out_is_stat), .out_word(out_word), .full(full), .empty(empty),
    .level(level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_byte(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (nak_pulse) nak_cnt++;
  endtask

  task automatic drive_end(input logic good, input logic [1:0] pid, input logic [3:0] ep);
    end_valid = 1'b1; end_good = good; end_pid = pid; end_ep = ep;
    @(posedge clk); @(negedge clk);
    end_valid = 1'b0;
    if (nak_pulse) nak_cnt++;
  endtask

  task automatic send_pkt(input int n, input logic [7:0] first, input logic [1:0] pid,
                          input logic [3:0] ep, input logic good);
    nak_cnt = 0;
    for (int i = 0; i < n; i++) drive_byte(first + 8'(i));
    drive_end(good, pid, ep);
  endtask

  task automatic pop(input string req, output logic st, output logic [17:0] w);
    chk(req, 32'(out_valid), 32'd1);
    st = out_is_stat; w = out_word;
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic drain_pkt(input int n, input logic [7:0] first, input logic [1:0] pid,
                           input logic [3:0] ep);
    logic st; logic [17:0] w;
    for (int i = 0; i < n; i++) begin
      pop("R2", st, w);
      chk("R1 data flag", 32'(st), 32'd0);
      chk("R2 data byte", 32'(w), 32'(first + 8'(i)));
    end
    pop("R2", st, w);
    chk("R1 status flag", 32'(st), 32'd1);
    chk("R1 status word", 32'(w), 32'({ep, 11'(n), pid, 1'b1}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic st; logic [17:0] w, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 empty", 32'(empty), 32'd1);
    chk("R11 full", 32'(full), 32'd0);
    chk("R11 level", 32'(level), 32'd0);
    chk("R11 out_valid", 32'(out_valid), 32'd0);
    chk("R11 nak", 32'(nak_pulse), 32'd0);

    // table walk: R4 exact fit, R5/R6 overflow, R7 bad packet
    for (int v = 0; v < 7; v++) begin
      send_pkt(int'(VECS[v].nb), VECS[v].first, VECS[v].pid, VECS[v].ep, VECS[v].good);
      chk("R5 R7 nak count", 32'(nak_cnt), 32'(VECS[v].exp_nak));
      if (VECS[v].good && !VECS[v].exp_nak) begin
        chk("R3 R4 level", 32'(level), 32'(VECS[v].nb) + 1);
        chk("R10 full", 32'(full), 32'(int'(VECS[v].nb) + 1 == DEPTH));
        drain_pkt(int'(VECS[v].nb), VECS[v].first, VECS[v].pid, VECS[v].ep);
      end else begin
        chk("R5 R6 R7 level", 32'(level), 32'd0);
        chk("R6 no status", 32'(out_valid), 32'd0);
      end
      chk("R10 empty", 32'(empty), 32'd1);
    end

    // R5 overflow with committed data present
    send_pkt(10, 8'h20, 2'd1, 4'd6, 1'b1);
    chk("R3 level", 32'(level), 32'd11);
    send_pkt(5, 8'h90, 2'd2, 4'd8, 1'b1);
    chk("R5 nak partial room", 32'(nak_cnt), 32'd1);
    chk("R5 level kept", 32'(level), 32'd11);
    send_pkt(4, 8'h30, 2'd2, 4'd9, 1'b1);
    chk("R4 exact fit", 32'(nak_cnt), 32'd0);
    chk("R10 full", 32'(full), 32'd1);
    drain_pkt(10, 8'h20, 2'd1, 4'd6);
    drain_pkt(4, 8'h30, 2'd2, 4'd9);
    chk("R10 empty", 32'(empty), 32'd1);

    // R8 pop while writing, R3 speculative bytes hidden
    send_pkt(2, 8'h50, 2'd0, 4'd10, 1'b1);
    for (int i = 0; i < 3; i++) begin
      chk("R8 valid", 32'(out_valid), 32'd1);
      st = out_is_stat; w = out_word;
      in_valid = 1'b1; in_byte = 8'hE0 + 8'(i); out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0;
      if (i < 2) chk("R8 data", 32'(w), 32'h50 + 32'(i));
      else       chk("R8 status", 32'(w), 32'({4'd10, 11'd2, 2'd0, 1'b1}));
    end
    chk("R3 hidden valid", 32'(out_valid), 32'd0);
    chk("R3 hidden level", 32'(level), 32'd0);
    drive_byte(8'hE3);
    drive_end(1'b1, 2'd1, 4'd11);
    chk("R3 commit level", 32'(level), 32'd5);
    // R9 back-pressure
    held = out_word;
    repeat (3) @(negedge clk);
    chk("R9 hold valid", 32'(out_valid), 32'd1);
    chk("R9 hold word", 32'(out_word), 32'(held));
    drain_pkt(4, 8'hE0, 2'd1, 4'd11);

    // R10 full from speculative bytes only, then R7 bad discard
    nak_cnt = 0;
    for (int i = 0; i < DEPTH; i++) drive_byte(8'(i));
    chk("R10 spec full", 32'(full), 32'd1);
    chk("R10 spec empty", 32'(empty), 32'd1);
    drive_end(1'b0, 2'd0, 4'd0);
    chk("R7 no nak", 32'(nak_cnt), 32'd0);
    chk("R7 full cleared", 32'(full), 32'd0);
    chk("R7 empty", 32'(empty), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule